// File: doc/BRIEF.md
# RAID Parity Stream Engine

The engine turns a set of equal-length source blocks into RAID parity as they stream past. A command selects one of three operations: a single weighted XOR, where every source is multiplied in GF(2^8) by its own coefficient before the sum (all-ones coefficients give plain parity); a dual-output pass that produces the plain XOR (P) and a coefficient-weighted XOR (Q) together; or a move that copies one source unchanged. Source words are presented interleaved: for each word offset of the block, one word from every source, in source index order. One parity word leaves per offset, and the final one is flagged.

The reduction polynomial used by the field multiplier lives in a writable register, so the block is not tied to one field. Commands that ask for too many or too few sources, an undefined operation, or an empty or oversized block are refused with an error flag and produce no output. A Q-only result for a single source is obtained by feeding that source twice with a zero coefficient on the second copy.

Top module: `raid_pq_engine`

## Requirements
- R1: After reset cmd_ready is 1, s_ready is 0, m_valid is 0, cmd_err is 0 and the polynomial register holds 0x1D (field x^8 + 0x1D).
- R2: cmd_op encodes 2'b00 = move, 2'b01 = single weighted XOR, 2'b10 = dual P+Q; 2'b11 is refused with cmd_err. A command is taken when cmd_valid and cmd_ready are both 1; cmd_ready is 0 while a job runs.
- R3: cmd_srcs_m1 holds the source count minus one. For weighted XOR and P+Q a count below 2 or above 16 is refused: cmd_err is set, no data is accepted and no output is produced. cmd_err is rewritten by every taken command.
- R4: cmd_len is the block length in words of 4 bytes; 0 or more than 262144 words (1 MiB) is refused with cmd_err, while exactly 262144 is accepted.
- R5: Data arrives offset by offset, source 0 first; one output word follows the last source word of each offset.
- R6: Weighted XOR: per byte lane m_p = XOR over sources of coef[i]·src[i] in GF(2^8); m_q = 0. Coefficient i sits in cmd_coef bits [8i+7:8i].
- R7: P+Q: per byte lane m_p = XOR of all sources and m_q = XOR of coef[i]·src[i].
- R8: The GF product reduces by x^8 plus the polynomial register, which is loaded from cfg_poly when cfg_poly_we is 1.
- R9: Move copies each input word to m_p with m_q = 0, one output per input word; cmd_srcs_m1 is ignored.
- R10: m_last is 1 on the output word of the final offset and 0 on all others.
- R11: While m_valid is 1 and m_ready is 0, m_p, m_q and m_last hold.
- R12: A coefficient of 0 removes its source from the weighted sum, so a repeated source with coefficients {c, 0} yields c·src.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_poly_we | input | 1 | Load polynomial register |
| cfg_poly | input | 8 | Low byte of the reduction polynomial |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | Operation code |
| cmd_srcs_m1 | input | 5 | Source count minus one |
| cmd_len | input | 20 | Block length in words |
| cmd_coef | input | 128 | Sixteen 8-bit coefficients |
| cmd_err | output | 1 | Last taken command was refused |
| s_valid | input | 1 | Source word offered |
| s_ready | output | 1 | Source word accepted |
| s_data | input | 32 | Source word, four byte lanes |
| m_valid | output | 1 | Parity word available |
| m_ready | input | 1 | Parity word consumed |
| m_p | output | 32 | P, weighted sum or moved word |
| m_q | output | 32 | Q in P+Q mode, else zero |
| m_last | output | 1 | Final offset of the block |

## Verification
The hardest situation to reach is an output word stalled by the consumer at the very moment the last source word of the next offset arrives, because the new result must wait behind the held one without being lost or merged. The stimulus throttles m_ready at random on most jobs while sources stream back to back, so the stall and release overlap with offset boundaries many times. The 1 MiB length edge is reached by issuing a command of exactly the limit, observing that it is taken, and then resetting rather than streaming it.

// File: rtl/raid_pq_engine.sv
module raid_pq_engine #(
  parameter int LANES     = 4,
  parameter int MAX_SRC   = 16,
  parameter int LEN_W     = 20,
  parameter int MAX_BYTES = 1 << 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_poly_we,
  input  logic [7:0]             cfg_poly,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [1:0]             cmd_op,
  input  logic [$clog2(MAX_SRC):0] cmd_srcs_m1,
  input  logic [LEN_W-1:0]       cmd_len,
  input  logic [MAX_SRC*8-1:0]   cmd_coef,
  output logic                   cmd_err,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [LANES*8-1:0]     s_data,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [LANES*8-1:0]     m_p,
  output logic [LANES*8-1:0]     m_q,
  output logic                   m_last
);
  localparam int DW = LANES * 8;
  localparam int IW = $clog2(MAX_SRC);
  localparam int SW = IW + 1;
  localparam logic [LEN_W:0] MAX_WORDS = (LEN_W+1)'(MAX_BYTES / LANES);
  localparam logic [1:0] OP_MOVE = 2'd0, OP_WXOR = 2'd1, OP_PQ = 2'd2;

  logic [7:0]       poly_r;
  logic             busy;
  logic [1:0]       op_r;
  logic [SW-1:0]    nm1_r, src_i;
  logic [LEN_W-1:0] len_r, off_i;
  logic [7:0]       coef_a [MAX_SRC];
  logic [DW-1:0]    acc_p, acc_q, prod, p_in, q_in, nxt_p, nxt_q;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] p);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 7; k >= 0; k--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? p : 8'h00);
      if (b[k]) r = r ^ a;
    end
    return r;
  endfunction

  wire cmd_bad = (cmd_op == 2'd3)
              || (cmd_op != OP_MOVE && (cmd_srcs_m1 == '0 || cmd_srcs_m1 > SW'(MAX_SRC-1)))
              || (cmd_len == '0) || ({1'b0, cmd_len} > MAX_WORDS);
  wire cmd_fire = cmd_valid && cmd_ready;
  wire s_fire   = s_valid && s_ready;
  wire last_src = (op_r == OP_MOVE) || (src_i == nm1_r);
  wire last_off = (off_i == len_r - LEN_W'(1));
  wire [7:0] cur_coef = coef_a[src_i[IW-1:0]];

  assign cmd_ready = !busy;
  assign s_ready   = busy && (!m_valid || m_ready);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign prod[g*8 +: 8] = gf_mul(s_data[g*8 +: 8], cur_coef, poly_r);
    end
  endgenerate

  assign p_in  = (op_r == OP_WXOR) ? prod : s_data;
  assign q_in  = (op_r == OP_PQ) ? prod : '0;
  assign nxt_p = ((src_i == '0) ? '0 : acc_p) ^ p_in;
  assign nxt_q = ((src_i == '0) ? '0 : acc_q) ^ q_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poly_r  <= 8'h1D;
      busy    <= 1'b0;
      op_r    <= OP_MOVE;
      nm1_r   <= '0;
      len_r   <= '0;
      src_i   <= '0;
      off_i   <= '0;
      acc_p   <= '0;
      acc_q   <= '0;
      cmd_err <= 1'b0;
      m_valid <= 1'b0;
      m_p     <= '0;
      m_q     <= '0;
      m_last  <= 1'b0;
      for (int i = 0; i < MAX_SRC; i++) coef_a[i] <= 8'h00;
    end else begin
      if (cfg_poly_we) poly_r <= cfg_poly;
      if (cmd_fire) begin
        cmd_err <= cmd_bad;
        if (!cmd_bad) begin
          busy  <= 1'b1;
          op_r  <= cmd_op;
          nm1_r <= cmd_srcs_m1;
          len_r <= cmd_len;
          src_i <= '0;
          off_i <= '0;
          for (int i = 0; i < MAX_SRC; i++) coef_a[i] <= cmd_coef[i*8 +: 8];
        end
      end
      if (s_fire) begin
        acc_p <= nxt_p;
        acc_q <= nxt_q;
        if (last_src) begin
          src_i <= '0;
          off_i <= off_i + LEN_W'(1);
          if (last_off) busy <= 1'b0;
        end else begin
          src_i <= src_i + SW'(1);
        end
      end
      if (s_fire && last_src) begin
        m_valid <= 1'b1;
        m_p     <= nxt_p;
        m_q     <= nxt_q;
        m_last  <= last_off;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_p) && $stable(m_q) && $stable(m_last));

  assert_refused_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_bad |=> cmd_ready && !s_ready && cmd_err);

  assert_src_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_r != OP_MOVE |-> nm1_r != '0 && nm1_r <= SW'(MAX_SRC-1));

  assert_move_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && op_r == OP_MOVE |=> m_valid && m_p == $past(s_data) && m_q == '0);

  assert_last_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && last_src && last_off |=> m_valid && m_last && cmd_ready);

  assert_mid_not_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && last_src && !last_off |=> m_valid && !m_last && !cmd_ready);
endmodule

// File: tb/raid_pq_engine_tb.sv
`timescale 1ns/1ps
module raid_pq_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_poly_we = 1'b0;
  logic [7:0] cfg_poly = 8'h00;
  logic cmd_valid = 1'b0, cmd_ready, cmd_err;
  logic [1:0] cmd_op = 2'd0;
  logic [4:0] cmd_srcs_m1 = 5'd0;
  logic [19:0] cmd_len = 20'd0;
  logic [127:0] cmd_coef = '0;
  logic s_valid = 1'b0, s_ready;
  logic [31:0] s_data = '0;
  logic m_valid, m_ready = 1'b0, m_last;
  logic [31:0] m_p, m_q;

  raid_pq_engine u_dut (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0, fast = 1'b0;
  logic [7:0]  ref_poly = 8'h1D;
  logic [31:0] srcw [16][8];
  logic [7:0]  coef [16];
  logic [31:0] exp_p [$], exp_q [$];
  bit          exp_l [$];
  string       cur_req = "R6";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00, aa = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc ^= aa;
      aa = aa[7] ? ((aa << 1) ^ ref_poly) : (aa << 1);
    end
    return acc;
  endfunction

  function automatic logic [31:0] mul_word(input logic [31:0] w, input logic [7:0] c);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = ref_mul(w[l*8 +: 8], c);
    return r;
  endfunction

  // consumer and cycle-by-cycle comparison
  bit prev_stall = 1'b0;
  logic [31:0] held_p, held_q;
  bit held_l;
  always @(negedge clk) begin
    bit r;
    if (rst_n) begin
      r = fast || ($urandom % 4 != 0);
      if (prev_stall)
        chk(m_valid && m_p == held_p && m_q == held_q && m_last == held_l, "R11",
            "held output", {m_q, m_p}, {held_q, held_p});
      m_ready = r;
      if (m_valid && r) begin
        if (exp_p.size() == 0) chk(1'b0, cur_req, "unexpected output", m_p, 0);
        else begin
          logic [31:0] ep, eq; bit el;
          ep = exp_p.pop_front(); eq = exp_q.pop_front(); el = exp_l.pop_front();
          chk(m_p == ep, cur_req, "m_p", m_p, ep);
          chk(m_q == eq, cur_req, "m_q", m_q, eq);
          chk(m_last == el, "R10", "m_last", m_last, el);
        end
      end
      prev_stall = m_valid && !r;
      held_p = m_p; held_q = m_q; held_l = m_last;
    end else begin
      m_ready = 1'b0;
      prev_stall = 1'b0;
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0; s_valid = 1'b0; cfg_poly_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ref_poly = 8'h1D;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [4:0] nm1, input logic [19:0] len);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_srcs_m1 = nm1; cmd_len = len;
    for (int i = 0; i < 16; i++) cmd_coef[i*8 +: 8] = coef[i];
    #3;
    while (!cmd_ready) begin @(negedge clk); #3; end
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_job(input logic [1:0] op, input int nsrc, input int len, input bit qtrick);
    int ns;
    ns = (op == 2'd0) ? 1 : nsrc;
    for (int w = 0; w < len; w++) begin
      logic [31:0] p, q;
      for (int s = 0; s < 16; s++) srcw[s][w] = $urandom;
      if (qtrick) srcw[1][w] = srcw[0][w];
      p = '0; q = '0;
      if (qtrick) p = mul_word(srcw[0][w], coef[0]);
      else if (op == 2'd0) p = srcw[0][w];
      else for (int s = 0; s < nsrc; s++) begin
        if (op == 2'd1) p ^= mul_word(srcw[s][w], coef[s]);
        else begin p ^= srcw[s][w]; q ^= mul_word(srcw[s][w], coef[s]); end
      end
      exp_p.push_back(p); exp_q.push_back(q); exp_l.push_back(w == len - 1);
    end
    issue(op, 5'(nsrc - 1), 20'(len));
    chk(cmd_err == 1'b0, cur_req, "cmd_err on valid command", cmd_err, 0);
    for (int w = 0; w < len; w++)
      for (int s = 0; s < ns; s++) begin
        s_valid = 1'b1; s_data = srcw[s][w];
        #3;
        while (!s_ready) begin @(negedge clk); #3; end
        @(posedge clk);
        @(negedge clk);
      end
    s_valid = 1'b0;
    while (exp_p.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cmd_ready == 1'b1, "R2", "idle after job", cmd_ready, 1);
  endtask

  task automatic bad_cmd(input logic [1:0] op, input logic [4:0] nm1, input logic [19:0] len,
                         input string req);
    issue(op, nm1, len);
    chk(cmd_err == 1'b1, req, "cmd_err", cmd_err, 1);
    chk(cmd_ready == 1'b1, req, "cmd_ready after refusal", cmd_ready, 1);
    s_valid = 1'b1; s_data = 32'hDEAD_BEEF;
    repeat (3) begin
      #3;
      chk(!s_ready && !m_valid, req, "no data taken or produced", {s_ready, m_valid}, 0);
      @(negedge clk);
    end
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
    chk(s_ready == 1'b0, "R1", "s_ready", s_ready, 0);
    chk(m_valid == 1'b0, "R1", "m_valid", m_valid, 0);
    chk(cmd_err == 1'b0, "R1", "cmd_err", cmd_err, 0);

    cur_req = "R6";
    for (int i = 0; i < 16; i++) coef[i] = 8'h01;
    run_job(2'd1, 3, 4, 1'b0);

    cur_req = "R8";
    for (int i = 0; i < 16; i++) coef[i] = 8'($urandom);
    run_job(2'd1, 16, 3, 1'b0);

    cur_req = "R7";
    for (int i = 0; i < 16; i++) coef[i] = 8'($urandom);
    run_job(2'd2, 5, 5, 1'b0);

    cur_req = "R5";
    fast = 1'b1;
    run_job(2'd2, 2, 6, 1'b0);
    fast = 1'b0;

    cur_req = "R12";
    coef[0] = 8'h8E; coef[1] = 8'h00;
    run_job(2'd1, 2, 4, 1'b1);

    cur_req = "R9";
    run_job(2'd0, 7, 6, 1'b0);

    bad_cmd(2'd3, 5'd2, 20'd4, "R2");
    bad_cmd(2'd1, 5'd0, 20'd4, "R3");
    bad_cmd(2'd2, 5'd16, 20'd4, "R3");
    bad_cmd(2'd1, 5'd3, 20'd0, "R4");
    bad_cmd(2'd0, 5'd0, 20'd262145, "R4");

    cur_req = "R8";
    @(negedge clk);
    cfg_poly_we = 1'b1; cfg_poly = 8'h2B;
    @(negedge clk);
    cfg_poly_we = 1'b0; ref_poly = 8'h2B;
    for (int i = 0; i < 16; i++) coef[i] = 8'($urandom);
    run_job(2'd2, 4, 3, 1'b0);

    issue(2'd0, 5'd0, 20'd262144);
    chk(cmd_err == 1'b0, "R4", "limit length accepted", cmd_err, 0);
    chk(cmd_ready == 1'b0, "R4", "limit length busy", cmd_ready, 0);
    do_reset();
    chk(cmd_ready == 1'b1 && m_valid == 1'b0, "R1", "state after second reset",
        {cmd_ready, m_valid}, 2'b10);

    cur_req = "R8";
    coef[0] = 8'h02; coef[1] = 8'h80;
    run_job(2'd1, 2, 2, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule